// File: doc/BRIEF.md
# Page-Granular Peripheral Address Router

This block sits between a CPU-side access port and a set of peripheral targets that share one address window. The window is cut into 4 KiB pages, and a routing table holds, for every page, the identifier of the target that owns it. An access that lands on an owned page is forwarded to that target. The forwarded request carries the address, the access size (byte, halfword or word), the write flag and the write data. The target's acknowledge and read data come back to the CPU as a one-cycle response.

The table is filled at configuration time by attach commands. Each command gives a region offset inside the window, a region size, the owning target and a region index with the agent's region count. A valid command walks the covered pages one per cycle and holds the access port off while it runs. Page 0 of the table is the window base. Identifier 0 means "no owner". An access to an unowned page, or to an address outside the window, gets a decode-error response instead of a target request.

After reset the block clears the whole table by itself, using the same page walk, before it accepts any access.

Top module: `pgr_router`

## Requirements
- R1: After reset, `att_busy` is high and `cpu_ready` is low while the table is cleared. This lasts DEPTH+1 cycles (181 by default), and every page is unowned afterwards.
- R2: The page index of an access is (`cpu_addr` − BASE) >> 12. An access to a page owned by target T raises `tgt_valid` with `tgt_id` = T and passes on `tgt_addr` = `cpu_addr`, `tgt_we` and `tgt_wdata`. These stay stable until `tgt_ack`.
- R3: `tgt_size` equals the `cpu_size` of the access, encoded as 0 = byte, 1 = halfword, 2 = word.
- R4: An accepted attach writes `att_target` into ceil(`att_size`/4096) pages, starting at page `att_offset` >> 12. `att_busy` stays high for one cycle per page plus one. A later attach overrides earlier owners, and a size of 0 writes nothing.
- R5: An attach is rejected if `att_region` (two's complement) is negative, if it is not below `att_nregions`, or if `att_offset` is not 4 KiB aligned. A rejected attach pulses `att_err` for one cycle, leaves `att_busy` low and leaves the table unchanged.
- R6: An attach whose `att_target` is 0 or 125 or more is rejected in the same way as R5.
- R7: An access to an unowned page, or to an address outside [BASE, BASE+0xB4000), responds with `resp_err` = 1 and `resp_rdata` = 0, and no `tgt_valid` is raised.
- R8: `cpu_ready` is low whenever `att_busy` is high, so no access is accepted during a page walk.
- R9: `resp_valid` pulses for one cycle, one cycle after `tgt_ack` is seen. It carries `resp_err` = 0, and `resp_rdata` = `tgt_rdata` for a read or 0 for a write.
- R10: An attach that runs past the window end writes only the pages below page 180. It then ends, with busy lasting the written-page count plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Access byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Block can accept an access this cycle |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Decode error on this response |
| resp_rdata | output | 32 | Read data of the response |
| att_valid | input | 1 | Attach command strobe |
| att_region | input | 8 | Region index, two's complement |
| att_nregions | input | 8 | Region count of the agent |
| att_offset | input | 20 | Region offset inside the window |
| att_size | input | 20 | Region size in bytes |
| att_target | input | 7 | Owning target identifier |
| att_busy | output | 1 | Page walk in progress |
| att_err | output | 1 | One-cycle attach rejection pulse |
| tgt_valid | output | 1 | Request to the selected target |
| tgt_id | output | 7 | Selected target identifier |
| tgt_we | output | 1 | Forwarded write flag |
| tgt_size | output | 2 | Forwarded access size |
| tgt_addr | output | 32 | Forwarded address |
| tgt_wdata | output | 32 | Forwarded write data |
| tgt_ack | input | 1 | Target acknowledge |
| tgt_rdata | input | 32 | Target read data |

## Verification
The assertions assume that `tgt_ack` is only meaningful while `tgt_valid` is high. They also assume that attach fields are sampled only in the cycle `att_valid` is high and the walk is idle, and that `cpu_req` matters only in cycles where `cpu_ready` is high. The stimulus respects these assumptions. Its responder acknowledges in the same cycle a request appears. Access and attach strobes are raised for exactly one cycle, and only after `cpu_ready` or a low `att_busy` has been seen. No access is issued while an attach command is pending.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_LOOK = 2'd1,
    ACC_WAIT = 2'd2
  } acc_state_e;
endpackage

// File: rtl/pgr_table.sv
module pgr_table #(
  parameter int IDX_W = 8,
  parameter int ID_W  = 7,
  parameter int DEPTH = 180
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ID_W-1:0]  wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ID_W-1:0]  rd_data
);
  logic [ID_W-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/pgr_attach.sv
module pgr_attach #(
  parameter int IDX_W     = 8,
  parameter int OFF_W     = 20,
  parameter int PAGE_BITS = 12,
  parameter int ID_W      = 7,
  parameter int REG_W     = 8,
  parameter int DEPTH     = 180,
  parameter int MAX_TGT   = 125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok,
  input  logic             cmd_valid,
  input  logic [REG_W-1:0] cmd_region,
  input  logic [REG_W-1:0] cmd_nregions,
  input  logic [OFF_W-1:0] cmd_offset,
  input  logic [OFF_W-1:0] cmd_size,
  input  logic [ID_W-1:0]  cmd_target,
  output logic             busy,
  output logic             err,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [ID_W-1:0]  wr_data
);
  localparam int PG_W  = IDX_W + 1;
  localparam int CNT_W = OFF_W - PAGE_BITS + 1;
  localparam logic [PG_W-1:0] PG_END = PG_W'(DEPTH);

  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] left_q;
  logic [ID_W-1:0]  owner_q;

  logic             bad_region, bad_target, bad_align, reject;
  logic [PG_W-1:0]  first_page;
  logic [CNT_W-1:0] npages;

  always_comb begin
    bad_region = cmd_region[REG_W-1] || (cmd_region >= cmd_nregions);
    bad_target = (cmd_target == '0) || (cmd_target >= ID_W'(MAX_TGT));
    bad_align  = |cmd_offset[PAGE_BITS-1:0];
    reject     = bad_region || bad_target || bad_align;
    first_page = PG_W'(cmd_offset[OFF_W-1:PAGE_BITS]);
    npages     = CNT_W'(cmd_size[OFF_W-1:PAGE_BITS])
               + CNT_W'(|cmd_size[PAGE_BITS-1:0]);
  end

  assign wr_en   = busy && (left_q != '0) && (page_q < PG_END);
  assign wr_idx  = page_q[IDX_W-1:0];
  assign wr_data = owner_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      // Reset reuses the walk to clear every page to "no owner".
      busy    <= 1'b1;
      err     <= 1'b0;
      page_q  <= '0;
      left_q  <= CNT_W'(DEPTH);
      owner_q <= '0;
    end else begin
      err <= 1'b0;
      if (!busy) begin
        if (cmd_valid && start_ok) begin
          if (reject) begin
            err <= 1'b1;
          end else begin
            busy    <= 1'b1;
            page_q  <= first_page;
            left_q  <= npages;
            owner_q <= cmd_target;
          end
        end
      end else if (wr_en) begin
        page_q <= page_q + 1'b1;
        left_q <= left_q - 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assert_reject_no_walk_R5: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  assert_walk_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && left_q == '0) |=> !busy);

  assert_walk_clips_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && page_q >= PG_END) |=> !busy);
endmodule

// File: rtl/pgr_access.sv
module pgr_access #(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter logic [31:0]     BASE      = 32'h4800_0000,
  parameter logic [31:0]     WINDOW    = 32'h000B_4000,
  parameter int              PAGE_BITS = 12,
  parameter int              IDX_W     = 8,
  parameter int              ID_W      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              idle,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [ID_W-1:0]   tbl_id,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              tgt_valid,
  output logic [ID_W-1:0]   tgt_id,
  output logic              tgt_we,
  output logic [1:0]        tgt_size,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_ack,
  input  logic [DATA_W-1:0] tgt_rdata
);
  import pgr_pkg::*;

  acc_state_e        st;
  logic [ADDR_W-1:0] off;
  logic              in_win, accept;
  logic              inwin_q;

  assign idle      = (st == ACC_IDLE);
  assign cpu_ready = idle && !hold;
  assign accept    = cpu_req && cpu_ready;
  assign off       = cpu_addr - ADDR_W'(BASE);
  assign in_win    = off < ADDR_W'(WINDOW);
  assign rd_idx    = off[PAGE_BITS +: IDX_W];
  assign rd_en     = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ACC_IDLE;
      inwin_q    <= 1'b0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
      tgt_valid  <= 1'b0;
      tgt_id     <= '0;
      tgt_we     <= 1'b0;
      tgt_size   <= '0;
      tgt_addr   <= '0;
      tgt_wdata  <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        ACC_IDLE: if (accept) begin
          inwin_q   <= in_win;
          tgt_we    <= cpu_we;
          tgt_size  <= cpu_size;
          tgt_addr  <= cpu_addr;
          tgt_wdata <= cpu_wdata;
          st        <= ACC_LOOK;
        end
        ACC_LOOK: begin
          if (!inwin_q || tbl_id == '0) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            resp_rdata <= '0;
            st         <= ACC_IDLE;
          end else begin
            tgt_valid <= 1'b1;
            tgt_id    <= tbl_id;
            st        <= ACC_WAIT;
          end
        end
        ACC_WAIT: if (tgt_ack) begin
          tgt_valid  <= 1'b0;
          resp_valid <= 1'b1;
          resp_err   <= 1'b0;
          resp_rdata <= tgt_we ? '0 : tgt_rdata;
          st         <= ACC_IDLE;
        end
        default: st <= ACC_IDLE;
      endcase
    end
  end

  assert_err_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> (resp_rdata == '0));

  assert_tgt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tgt_valid && !tgt_ack) |=> (tgt_valid && $stable(tgt_id) && $stable(tgt_addr)));

  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

// File: rtl/pgr_router.sv
module pgr_router #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] BASE      = 32'h4800_0000,
  parameter logic [31:0] WINDOW    = 32'h000B_4000,
  parameter int          PAGE_BITS = 12,
  parameter int          MAX_TGT   = 125,
  parameter int          REG_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [1:0]                   cpu_size,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         resp_valid,
  output logic                         resp_err,
  output logic [DATA_W-1:0]            resp_rdata,
  input  logic                         att_valid,
  input  logic [REG_W-1:0]             att_region,
  input  logic [REG_W-1:0]             att_nregions,
  input  logic [$clog2(WINDOW)-1:0]    att_offset,
  input  logic [$clog2(WINDOW)-1:0]    att_size,
  input  logic [$clog2(MAX_TGT)-1:0]   att_target,
  output logic                         att_busy,
  output logic                         att_err,
  output logic                         tgt_valid,
  output logic [$clog2(MAX_TGT)-1:0]   tgt_id,
  output logic                         tgt_we,
  output logic [1:0]                   tgt_size,
  output logic [ADDR_W-1:0]            tgt_addr,
  output logic [DATA_W-1:0]            tgt_wdata,
  input  logic                         tgt_ack,
  input  logic [DATA_W-1:0]            tgt_rdata
);
  localparam int DEPTH = int'(WINDOW >> PAGE_BITS);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OFF_W = $clog2(WINDOW);
  localparam int ID_W  = $clog2(MAX_TGT);

  logic             acc_idle;
  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [ID_W-1:0]  wr_data, rd_data;

  pgr_table #(.IDX_W(IDX_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_table (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  pgr_attach #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PAGE_BITS(PAGE_BITS), .ID_W(ID_W),
    .REG_W(REG_W), .DEPTH(DEPTH), .MAX_TGT(MAX_TGT)
  ) u_attach (
    .clk(clk), .rst(rst), .start_ok(acc_idle), .cmd_valid(att_valid),
    .cmd_region(att_region), .cmd_nregions(att_nregions),
    .cmd_offset(att_offset), .cmd_size(att_size), .cmd_target(att_target),
    .busy(att_busy), .err(att_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  // A pending attach command takes priority over a same-cycle access.
  pgr_access #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE), .WINDOW(WINDOW),
    .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W), .ID_W(ID_W)
  ) u_access (
    .clk(clk), .rst(rst), .hold(att_busy || att_valid),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .idle(acc_idle), .rd_en(rd_en), .rd_idx(rd_idx), .tbl_id(rd_data),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .tgt_valid(tgt_valid), .tgt_id(tgt_id), .tgt_we(tgt_we),
    .tgt_size(tgt_size), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  assert_hold_off_R8: assert property (@(posedge clk) disable iff (rst)
    att_busy |-> !cpu_ready);
endmodule

// File: tb/sim_pgr_router.sv
`timescale 1ns/1ps
module sim_pgr_router;
  localparam logic [31:0] BASE  = 32'h4800_0000;
  localparam int          PAGES = 180;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic        att_valid = 1'b0;
  logic [7:0]  att_region = '0, att_nregions = '0;
  logic [19:0] att_offset = '0, att_size = '0;
  logic [6:0]  att_target = '0;
  logic        att_busy, att_err;
  logic        tgt_valid, tgt_we, tgt_ack;
  logic [6:0]  tgt_id;
  logic [1:0]  tgt_size;
  logic [31:0] tgt_addr, tgt_wdata, tgt_rdata;

  always #2.5 clk = ~clk;

  pgr_router u0 (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .att_valid(att_valid), .att_region(att_region),
    .att_nregions(att_nregions), .att_offset(att_offset), .att_size(att_size),
    .att_target(att_target), .att_busy(att_busy), .att_err(att_err),
    .tgt_valid(tgt_valid), .tgt_id(tgt_id), .tgt_we(tgt_we),
    .tgt_size(tgt_size), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  // Target model: acknowledges at once, read data tags id and address.
  assign tgt_ack   = tgt_valid;
  assign tgt_rdata = {1'b0, tgt_id, tgt_addr[23:0]};

  int          tx_cnt;
  logic [6:0]  tx_id;
  logic [1:0]  tx_size;
  logic        tx_we;
  logic [31:0] tx_addr, tx_wd;
  always @(posedge clk) if (tgt_valid) begin
    tx_cnt  = tx_cnt + 1;
    tx_id   = tgt_id;
    tx_size = tgt_size;
    tx_we   = tgt_we;
    tx_addr = tgt_addr;
    tx_wd   = tgt_wdata;
  end

  int         n_chk = 0, n_fail = 0;
  logic [6:0] exp_tbl [PAGES];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input string req, input bit we, input logic [1:0] sz,
                           input logic [31:0] addr, input logic [31:0] wd);
    logic [31:0] off, exp_rd;
    logic [6:0]  id;
    bit          own;
    int          w;
    off = addr - BASE;
    id  = '0;
    if (off < 32'h000B_4000) id = exp_tbl[off[19:12]];
    own = (id != '0);
    while (!cpu_ready) @(negedge clk);
    tx_cnt = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    w = 0;
    while (!resp_valid && w < 20) begin @(negedge clk); w++; end
    chk(req, "response seen", {31'b0, resp_valid}, 32'd1);
    chk(req, "decode error", {31'b0, resp_err}, {31'b0, !own});
    exp_rd = (own && !we) ? {1'b0, id, addr[23:0]} : 32'h0;
    chk(req, "read data", resp_rdata, exp_rd);
    if (own) begin
      chk(req, "target count", tx_cnt, 1);
      chk(req, "target id", {25'b0, tx_id}, {25'b0, id});
      chk(req, "target addr", tx_addr, addr);
      chk("R3", "target size", {30'b0, tx_size}, {30'b0, sz});
      chk(req, "target we", {31'b0, tx_we}, {31'b0, we});
      if (we) chk(req, "target wdata", tx_wd, wd);
    end else begin
      chk(req, "no target request", tx_cnt, 0);
    end
  endtask

  task automatic do_attach(input string req, input logic [7:0] rg, input logic [7:0] nr,
                           input logic [19:0] off, input logic [19:0] sz,
                           input logic [6:0] tg, input bit exp_err);
    int start, n, busy_n;
    bit ready_low;
    while (att_busy) @(negedge clk);
    att_valid = 1'b1; att_region = rg; att_nregions = nr;
    att_offset = off; att_size = sz; att_target = tg;
    @(negedge clk);
    att_valid = 1'b0;
    chk(req, "attach error flag", {31'b0, att_err}, {31'b0, exp_err});
    if (exp_err) begin
      chk(req, "busy after reject", {31'b0, att_busy}, 32'd0);
    end else begin
      start = int'(off) >> 12;
      n = (int'(sz) + 4095) >> 12;
      if (start + n > PAGES) n = PAGES - start;
      if (n < 0) n = 0;
      for (int p = start; p < start + n; p++) exp_tbl[p] = tg;
      busy_n = 0; ready_low = 1'b1;
      while (att_busy && busy_n < 400) begin
        if (cpu_ready) ready_low = 1'b0;
        busy_n++;
        @(negedge clk);
      end
      chk(req, "busy cycles", busy_n, n + 1);
      chk("R8", "ready low while busy", {31'b0, ready_low}, 32'd1);
    end
  endtask

  task automatic t_reset();
    int busy_n;
    bit ready_low;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < PAGES; p++) exp_tbl[p] = '0;
    chk("R1", "busy after reset", {31'b0, att_busy}, 32'd1);
    chk("R1", "resp_valid after reset", {31'b0, resp_valid}, 32'd0);
    chk("R1", "tgt_valid after reset", {31'b0, tgt_valid}, 32'd0);
    busy_n = 0; ready_low = 1'b1;
    while (att_busy && busy_n < 400) begin
      if (cpu_ready) ready_low = 1'b0;
      busy_n++;
      @(negedge clk);
    end
    chk("R1", "clear cycles", busy_n, PAGES + 1);
    chk("R1", "ready low during clear", {31'b0, ready_low}, 32'd1);
    chk("R1", "ready after clear", {31'b0, cpu_ready}, 32'd1);
  endtask

  task automatic t_unowned();
    do_access("R7", 1'b0, 2'd2, BASE + 32'h0000_0000, 32'h0);
    do_access("R7", 1'b1, 2'd2, BASE + 32'h0005_0104, 32'hDEAD_BEEF);
    do_access("R7", 1'b0, 2'd2, BASE - 32'd4, 32'h0);
    do_access("R7", 1'b0, 2'd0, BASE + 32'h000B_4000, 32'h0);
  endtask

  task automatic t_basic_route();
    do_attach("R4", 8'd1, 8'd2, 20'h03000, 20'h02000, 7'd5, 1'b0);
    do_access("R2", 1'b0, 2'd2, BASE + 32'h0000_3010, 32'h0);
    do_access("R3", 1'b1, 2'd0, BASE + 32'h0000_4FFF, 32'hA5);
    do_access("R3", 1'b0, 2'd1, BASE + 32'h0000_4002, 32'h0);
    do_access("R9", 1'b1, 2'd2, BASE + 32'h0000_3FFC, 32'h1234_5678);
    do_access("R7", 1'b0, 2'd1, BASE + 32'h0000_5000, 32'h0);
    do_access("R7", 1'b0, 2'd2, BASE + 32'h0000_2FFC, 32'h0);
  endtask

  task automatic t_sizes_and_override();
    do_attach("R4", 8'd0, 8'd1, 20'h10000, 20'h01001, 7'd9, 1'b0);
    do_access("R4", 1'b0, 2'd2, BASE + 32'h0001_1FF0, 32'h0);
    do_access("R4", 1'b0, 2'd2, BASE + 32'h0001_2000, 32'h0);
    do_attach("R4", 8'd0, 8'd1, 20'h20000, 20'h00000, 7'd11, 1'b0);
    do_access("R4", 1'b0, 2'd2, BASE + 32'h0002_0000, 32'h0);
    do_attach("R4", 8'd3, 8'd4, 20'h04000, 20'h01000, 7'd7, 1'b0);
    do_access("R4", 1'b0, 2'd2, BASE + 32'h0000_4100, 32'h0);
    do_access("R4", 1'b0, 2'd2, BASE + 32'h0000_3100, 32'h0);
  endtask

  task automatic t_rejects();
    do_attach("R5", 8'hFF, 8'd4, 20'h30000, 20'h01000, 7'd20, 1'b1);
    do_attach("R5", 8'd4, 8'd4, 20'h30000, 20'h01000, 7'd20, 1'b1);
    do_attach("R5", 8'd0, 8'd4, 20'h03800, 20'h01000, 7'd20, 1'b1);
    do_attach("R6", 8'd0, 8'd4, 20'h30000, 20'h01000, 7'd0, 1'b1);
    do_attach("R6", 8'd0, 8'd4, 20'h30000, 20'h01000, 7'd125, 1'b1);
    do_access("R5", 1'b0, 2'd2, BASE + 32'h0003_0000, 32'h0);
    do_access("R5", 1'b0, 2'd2, BASE + 32'h0000_3000, 32'h0);
    do_attach("R6", 8'd0, 8'd4, 20'h30000, 20'h01000, 7'd124, 1'b0);
    do_access("R6", 1'b0, 2'd2, BASE + 32'h0003_0008, 32'h0);
  endtask

  task automatic t_clip();
    do_attach("R10", 8'd0, 8'd1, 20'hB2000, 20'h05000, 7'd100, 1'b0);
    do_access("R10", 1'b0, 2'd2, BASE + 32'h000B_3FFC, 32'h0);
    do_access("R10", 1'b0, 2'd2, BASE + 32'h000B_2000, 32'h0);
    do_access("R10", 1'b0, 2'd2, BASE + 32'h000B_4000, 32'h0);
    do_attach("R10", 8'd0, 8'd1, 20'hF0000, 20'h02000, 7'd3, 1'b0);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < PAGES; p++)
      do_access("R2", 1'b0, 2'd2, BASE + 32'(p) * 32'h1000 + 32'h8, 32'h0);
  endtask

  initial begin
    tx_cnt = 0;
    t_reset();
    t_unowned();
    t_basic_route();
    t_sizes_and_override();
    t_rejects();
    t_clip();
    t_sweep();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule